// File: doc/BRIEF.md
# DMA Channel Enable and Completion Controller

This block holds the control state of a single DMA channel. Software programs a transfer count, a request mode (automatic or external) and an interrupt enable through a small register port. While the channel is permitted to run, the block issues one-cycle transfer strobes to the bus-master logic. It counts each strobe down and raises a completion flag and an interrupt when the count runs out.

The channel may run only when all of these hold: its own enable is set, the completion flag is clear, the global master enable is set, and neither the NMI flag nor the address-error flag is set. Stopping early leaves the completion flag clear. The completion flag can be cleared only by a write of zero that follows a read which returned it as one, or by the standby input.

Top module: `dma_chan_ctl`

## Requirements
- R1: After reset every register reads zero, `xfer_stb` is low and `irq` is low.
- R2: In automatic mode (control bit 3 = 1) with control bit 0 (channel enable) set, one strobe is issued per cycle. The first strobe appears in the second cycle after the enabling write. The number of strobes equals the loaded count N.
- R3: The strobe that takes the count (address 1) to zero also sets the completion flag (control bit 1). After that, no more strobes are issued while enable stays at 1.
- R4: `irq` is high exactly when the completion flag and the interrupt enable (control bit 2) are both 1.
- R5: In external mode (control bit 3 = 0), each one-cycle `ext_req` pulse accepted while the channel is permitted produces exactly one strobe, one cycle later. A pulse that arrives while the channel is disabled produces no strobe.
- R6: A write of 0 to control bit 1 clears the completion flag only if an earlier read of address 0 returned that bit as 1. A write of 1 has no effect. A read taken while the flag was 0 does not permit a later clear.
- R7: A `standby` pulse clears the completion flag.
- R8: No strobe is issued while the master enable (address 2, bit 0) is 0, the NMI flag (address 2, bit 1) is 1, or the address-error flag (address 2, bit 2) is 1.
- R9: The NMI and address-error flags are set by `nmi_pulse` and `aerr_pulse`. A write of 1 leaves them set. Only a write of 0 to the flag's bit clears it.
- R10: Clearing the channel enable during a run stops further strobes, leaves the completion flag at 0, and keeps the remaining count. `rdata` is valid in the cycle after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| standby | input | 1 | Standby entry; clears completion flag |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | 0 control, 1 count, 2 global |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Read data, one cycle after rd_en |
| ext_req | input | 1 | External transfer request pulse |
| nmi_pulse | input | 1 | Sets the NMI flag |
| aerr_pulse | input | 1 | Sets the address-error flag |
| xfer_stb | output | 1 | One-cycle transfer strobe |
| irq | output | 1 | Completion interrupt |

## Verification
Each strobe is registered, so it is due one cycle after the cycle in which its permission and request were present. That makes it two cycles after an enabling write, or one cycle after an `ext_req` pulse. Register reads return one cycle after `rd_en`. The bench drives every input on the falling edge and samples on the following falling edges. It counts strobes through an independent falling-edge counter, so that it can compare totals over windows wider than the latency. Counts are swept over several values, and the remaining count after a suspension is checked against the number of strobes observed.

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             standby,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [1:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  input  logic             ext_req,
  input  logic             nmi_pulse,
  input  logic             aerr_pulse,
  output logic             xfer_stb,
  output logic             irq
);
  localparam logic [1:0] A_CTRL = 2'd0, A_CNT = 2'd1, A_GLB = 2'd2;

  logic chan_en, done, irq_en, auto_mode, master_en, nmi_flag, aerr_flag, armed;
  logic [CNT_W-1:0] cnt;

  wire wr_ctrl = wr_en && addr == A_CTRL;
  wire wr_cnt  = wr_en && addr == A_CNT;
  wire wr_glb  = wr_en && addr == A_GLB;
  wire perm    = chan_en && !done && master_en && !nmi_flag && !aerr_flag && cnt != '0;
  wire issue   = perm && (auto_mode || ext_req);
  wire clr_ok  = wr_ctrl && !wdata[1] && armed;

  assign irq = done && irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_en <= 1'b0; done <= 1'b0; irq_en <= 1'b0; auto_mode <= 1'b0;
      master_en <= 1'b0; nmi_flag <= 1'b0; aerr_flag <= 1'b0; armed <= 1'b0;
      cnt <= '0; xfer_stb <= 1'b0; rdata <= '0;
    end else begin
      xfer_stb <= issue;
      if (wr_cnt) cnt <= wdata;
      else if (issue) cnt <= cnt - 1'b1;
      if (wr_ctrl) begin
        chan_en   <= wdata[0];
        irq_en    <= wdata[2];
        auto_mode <= wdata[3];
      end
      if (standby) done <= 1'b0;
      else if (issue && cnt == 1 && !wr_cnt) done <= 1'b1;
      else if (clr_ok) done <= 1'b0;
      if (standby || clr_ok) armed <= 1'b0;
      else if (rd_en && addr == A_CTRL && done) armed <= 1'b1;
      if (wr_glb) master_en <= wdata[0];
      if (nmi_pulse) nmi_flag <= 1'b1;
      else if (wr_glb && !wdata[1]) nmi_flag <= 1'b0;
      if (aerr_pulse) aerr_flag <= 1'b1;
      else if (wr_glb && !wdata[2]) aerr_flag <= 1'b0;
      if (rd_en) begin
        rdata <= '0;
        case (addr)
          A_CTRL: rdata[3:0] <= {auto_mode, irq_en, done, chan_en};
          A_CNT:  rdata <= cnt;
          A_GLB:  rdata[2:0] <= {aerr_flag, nmi_flag, master_en};
          default: rdata <= '0;
        endcase
      end
    end
  end

  // R3: completion rises only with the strobe that empties the counter
  a_r3_done_with_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> xfer_stb && cnt == '0);
  // R3: no strobe once completion was already set
  a_r3_no_stb_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done && $past(done) |-> !xfer_stb);
  // R6, R7: completion falls only by an armed zero write or standby
  a_r6_clear_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> $past(standby) || $past(wr_en && addr == A_CTRL && !wdata[1] && armed));
  // R9: the NMI flag survives anything but a zero write
  a_r9_nmi_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(nmi_flag) && !$past(wr_en && addr == A_GLB && !wdata[1]) |-> nmi_flag);
  // R2: each strobe matches a decrement of the counter
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_stb && !$past(wr_en && addr == A_CNT) |-> cnt == $past(cnt) - 1'b1);
  // R8: no strobe while the master enable was off
  a_r8_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(master_en) |-> !xfer_stb);
endmodule

// File: tb/dma_chan_ctl_test.sv
`timescale 1ns/1ps
module dma_chan_ctl_test;
  logic clk = 0, rst_n = 0, standby = 0, wr_en = 0, rd_en = 0;
  logic ext_req = 0, nmi_pulse = 0, aerr_pulse = 0;
  logic [1:0] addr = 0;
  logic [15:0] wdata = 0, rdata;
  logic xfer_stb, irq;
  int checks = 0, fails = 0, stbs = 0;
  logic [15:0] rv;

  always #2.5 clk = ~clk;

  dma_chan_ctl #(.CNT_W(16)) uut (.clk(clk), .rst_n(rst_n), .standby(standby),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .ext_req(ext_req), .nmi_pulse(nmi_pulse), .aerr_pulse(aerr_pulse),
    .xfer_stb(xfer_stb), .irq(irq));

  always @(negedge clk) if (rst_n && xfer_stb) stbs++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_req(output logic s);
    @(negedge clk); ext_req = 1;
    @(negedge clk); ext_req = 0; s = xfer_stb;
  endtask

  initial begin
    #(5ns * 20000);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int s0;
    logic s;
    idle(3); rst_n = 1; idle(1);
    // R1 reset state
    for (int a = 0; a < 3; a++) begin rd(a[1:0], rv); chk("R1 reg", rv, 0); end
    chk("R1 stb", xfer_stb, 0); chk("R1 irq", irq, 0);

    // R8 master enable off blocks
    wr(1, 4); s0 = stbs; wr(0, 16'h9); idle(6);
    chk("R8 master off", stbs - s0, 0);
    s0 = stbs; wr(2, 1); idle(8);
    chk("R2 after master on", stbs - s0, 4);
    rd(0, rv); chk("R3 ctrl", rv, 16'hB); chk("R4 irq off", irq, 0);
    wr(0, 0); rd(0, rv); chk("R6 armed clear", rv, 0);

    // R2/R3/R4 sweep over counts
    for (int n = 1; n <= 9; n += 2) begin
      wr(1, n[15:0]); s0 = stbs; wr(0, 16'hD);
      @(negedge clk); chk("R2 first strobe latency", xfer_stb, 1);
      idle(n + 4);
      chk("R2 strobe total", stbs - s0, n);
      chk("R4 irq", irq, 1);
      rd(1, rv); chk("R3 count zero", rv, 0);
      rd(0, rv); chk("R3 done set", rv, 16'hF);
      idle(3); chk("R3 no more strobes", stbs - s0, n);
      wr(0, 16'h4); rd(0, rv); chk("R6 clear after read", rv, 16'h4);
      chk("R4 irq low", irq, 0);
    end

    // R6 no arming from earlier zero read; write 1 no effect
    rd(0, rv); wr(1, 2); wr(0, 16'h9); idle(5);
    wr(0, 16'h9); rd(0, rv); chk("R6 unarmed zero write", rv, 16'hB);
    wr(0, 16'hB); rd(0, rv); chk("R6 write one", rv, 16'hB);
    // R7 standby
    @(negedge clk); standby = 1; @(negedge clk); standby = 0;
    rd(0, rv); chk("R7 standby clears", rv, 16'h9);
    wr(0, 0); idle(2);

    // R5 external mode
    wr(1, 2); pulse_req(s); chk("R5 disabled request", s, 0);
    wr(0, 16'h5); idle(2); chk("R5 no strobe without req", xfer_stb, 0);
    pulse_req(s); chk("R5 strobe 1", s, 1);
    @(negedge clk); chk("R5 single strobe", xfer_stb, 0);
    pulse_req(s); chk("R5 strobe 2", s, 1);
    chk("R4 ext irq", irq, 1);
    pulse_req(s); chk("R3 req after done", s, 0);
    rd(0, rv); wr(0, 0);

    // R8/R9 NMI and address error
    @(negedge clk); nmi_pulse = 1; @(negedge clk); nmi_pulse = 0;
    rd(2, rv); chk("R9 nmi set", rv, 3);
    wr(1, 3); s0 = stbs; wr(0, 16'h9); idle(5);
    chk("R8 nmi blocks", stbs - s0, 0);
    wr(2, 3); rd(2, rv); chk("R9 write one keeps", rv, 3);
    idle(3); chk("R8 nmi still blocks", stbs - s0, 0);
    @(negedge clk); aerr_pulse = 1; @(negedge clk); aerr_pulse = 0;
    wr(2, 16'h5); rd(2, rv); chk("R9 aerr set nmi cleared", rv, 5);
    idle(3); chk("R8 aerr blocks", stbs - s0, 0);
    wr(2, 1); idle(6); chk("R8 released", stbs - s0, 3);
    rd(0, rv); wr(0, 0);

    // R10 suspend
    wr(1, 10); s0 = stbs; wr(0, 16'h9); idle(2); wr(0, 0); idle(3);
    s0 = stbs - s0;
    chk("R10 partial run", (s0 > 0 && s0 < 10) ? 1 : 0, 1);
    rd(1, rv); chk("R10 remaining count", rv, 10 - s0);
    rd(0, rv); chk("R10 done stays clear", rv, 0);
    s0 = stbs; idle(4); chk("R10 suspended", stbs - s0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule